// File: doc/BRIEF.md
# Single-Channel Block-Move DMA Engine

This block moves a block of words between main memory and a device-side word port so that the processor does not have to copy them itself. Software programs three registers: a first word address, a word count, and a control/status word that holds the direction, the bus usage mode and the interrupt enable. It then sets the launch bit. The engine requests the memory bus from an external arbiter. For every word it drives the address, the write strobe and the data. It advances the address by one word and lowers the remaining count. It reports the end of the block through a completion flag and, if enabled, an interrupt line.

Two bus usage modes exist. In stealing mode the engine gives the bus back after every word and asks for it again for the next one. In burst mode it keeps the request asserted from the first grant until the block is finished. A memory-side wait input stretches any bus cycle. Reading the control/status register clears a pending interrupt.

The sequencer has five states. IDLE waits for a launch. DEVIN takes a word from the device. BUSREQ waits for the grant. MEMCYC runs one memory cycle until it is not stalled. DEVOUT hands a word to the device. The transitions are as follows. IDLE goes to BUSREQ on a memory-to-device launch and to DEVIN on a device-to-memory launch. A zero-count launch leaves IDLE at once with completion. DEVIN goes to BUSREQ, or straight to MEMCYC when it already owns the bus in burst mode. BUSREQ goes to MEMCYC on grant. MEMCYC goes to DEVOUT on a read, to DEVIN on a write that is not the last, and to IDLE on the last write. DEVOUT goes to IDLE after the last word, to MEMCYC in burst mode, and to BUSREQ in stealing mode.

Top module: `dma_chan`

## Requirements
- R1: After reset the control/status word reads 0, and `irq`, `bus_req` and `mem_valid` are low.
- R2: Register offset 0 holds the word address and offset 1 holds the remaining count. Both read back their live values. After a block of N words from address A, they read A+N and 0.
- R3: With control bit 0 (direction) at 1, the device port receives the words at memory addresses A to A+N-1 in ascending order.
- R4: With control bit 0 at 0, the words taken from the device are written to addresses A to A+N-1 in order, and address A+N is left unchanged.
- R5: Control bit 1 (complete) reads 0 while a block is in progress and reads 1 after it ends. An accepted launch clears it.
- R6: At completion, with control bit 30 (interrupt enable) at 1, `irq` and control bit 31 go to 1. With bit 30 at 0 both stay 0.
- R7: A read of the control/status word at offset 2 clears bit 31 and drops `irq`.
- R8: A launch with a count of 0 sets complete (and the interrupt, if enabled) on the next edge and issues no memory cycle.
- R9: With control bit 2 (burst) at 0, `bus_req` drops after every word, giving one request per word.
- R10: With control bit 2 at 1, `bus_req` stays high from the first grant until the block ends, giving one request per block.
- R11: Writing the launch bit (bit 4) while busy is ignored and sets the error flag (bit 3). The next accepted launch clears it.
- R12: While `mem_valid` and `mem_wait` are high, `mem_addr`, `mem_wdata` and `mem_we` stay stable into the next cycle.
- R13: A memory cycle is only driven while `bus_gnt` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| mem_valid | output | 1 | Memory cycle active |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_wait | input | 1 | Memory stall |
| dev_out_valid | output | 1 | Word offered to device |
| dev_out_ready | input | 1 | Device accepts word |
| dev_out_data | output | DW | Word to device |
| dev_in_valid | input | 1 | Device offers word |
| dev_in_ready | output | 1 | Engine accepts word |
| dev_in_data | input | DW | Word from device |

## Verification
The assertions check, on every cycle, the following: stall stability of the memory cycle, that a cycle is driven only under grant, the one-word step of address and count, that the bus is released after each word in stealing mode and held in burst mode, that the completion flag is clear while busy, the interrupt set and read-clear, and the error on a busy launch. Only the bench scenarios can show that the right data lands in the right place and in order in both directions, that nothing past the block is overwritten, the exact request counts per block, the zero-count shortcut, and that a rejected launch leaves the running block unchanged.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int REG_W = 32;

    localparam logic [1:0] OFS_ADDR = 2'd0;
    localparam logic [1:0] OFS_CNT  = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    localparam int B_DIR   = 0;
    localparam int B_DONE  = 1;
    localparam int B_BURST = 2;
    localparam int B_ERR   = 3;
    localparam int B_START = 4;
    localparam int B_IE    = 30;
    localparam int B_IRQ   = 31;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEVIN,
        S_BUSREQ,
        S_MEMCYC,
        S_DEVOUT
    } seq_state_t;
endpackage

// File: rtl/dma_csr.sv
module dma_csr
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             word_step,
    input  logic             fin,
    output logic             start_go,
    output logic             dir_eff,
    output logic             burst_eff,
    output logic             cnt_zero,
    output logic             cnt_last,
    output logic [AW-1:0]    addr_out,
    output logic             irq
);
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          dir_q, burst_q, ie_q, done_q, err_q, irq_q;
    logic          wr, rd_ctrl, start_wr, ie_eff;
    logic [REG_W-1:0] ctrl_view;
    logic          unused_wbits;

    assign unused_wbits = ^reg_wdata;

    assign wr        = reg_en && reg_we;
    assign rd_ctrl   = reg_en && !reg_we && (reg_addr == OFS_CTRL);
    assign start_wr  = wr && (reg_addr == OFS_CTRL) && reg_wdata[B_START];
    assign start_go  = start_wr && !busy;
    assign dir_eff   = start_go ? reg_wdata[B_DIR]   : dir_q;
    assign burst_eff = start_go ? reg_wdata[B_BURST] : burst_q;
    assign ie_eff    = start_go ? reg_wdata[B_IE]    : ie_q;
    assign cnt_zero  = (cnt_q == '0);
    assign cnt_last  = (cnt_q == CW'(1));
    assign addr_out  = addr_q;
    assign irq       = irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
            burst_q <= 1'b0;
            ie_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (wr && !busy) begin
                case (reg_addr)
                    OFS_ADDR: addr_q <= reg_wdata[AW-1:0];
                    OFS_CNT:  cnt_q  <= reg_wdata[CW-1:0];
                    OFS_CTRL: begin
                        dir_q   <= reg_wdata[B_DIR];
                        burst_q <= reg_wdata[B_BURST];
                        ie_q    <= reg_wdata[B_IE];
                    end
                    default: ;
                endcase
            end
            if (word_step) begin
                addr_q <= addr_q + AW'(1);
                cnt_q  <= cnt_q - CW'(1);
            end
            if (start_go) begin
                done_q <= 1'b0;
                irq_q  <= 1'b0;
                err_q  <= 1'b0;
            end else if (start_wr) begin
                err_q <= 1'b1;
            end
            if (rd_ctrl) irq_q <= 1'b0;
            if (fin) begin
                done_q <= 1'b1;
                if (ie_eff) irq_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ctrl_view          = '0;
        ctrl_view[B_DIR]   = dir_q;
        ctrl_view[B_DONE]  = done_q;
        ctrl_view[B_BURST] = burst_q;
        ctrl_view[B_ERR]   = err_q;
        ctrl_view[B_IE]    = ie_q;
        ctrl_view[B_IRQ]   = irq_q;
    end

    always_comb begin
        case (reg_addr)
            OFS_ADDR: reg_rdata = REG_W'(addr_q);
            OFS_CNT:  reg_rdata = REG_W'(cnt_q);
            OFS_CTRL: reg_rdata = ctrl_view;
            default:  reg_rdata = '0;
        endcase
    end

    // R2: each completed word advances address by one and lowers count by one
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_step |=> (addr_q == $past(addr_q) + AW'(1)) && (cnt_q == $past(cnt_q) - CW'(1)));

    // R5: completion flag never reads 1 while a block runs
    assert_done_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done_q);

    // R6: completion sets done and sets irq exactly when enabled
    assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done_q && (irq_q == $past(ie_eff)));

    // R7: status read without a coincident completion clears the interrupt
    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !fin) |=> !irq_q);

    // R11: launch while busy raises the error flag
    assert_busy_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && busy) |=> err_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_go,
    input  logic          dir,
    input  logic          burst,
    input  logic          cnt_zero,
    input  logic          cnt_last,
    input  logic          bus_gnt,
    output logic          bus_req,
    input  logic          mem_wait,
    output logic          mem_valid,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data,
    output logic          word_step,
    output logic          fin,
    output logic          busy
);
    seq_state_t    state_q, state_d;
    logic          own_q;
    logic [DW-1:0] data_q;

    always_comb begin
        state_d   = state_q;
        fin       = 1'b0;
        word_step = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_go) begin
                    if (cnt_zero)  fin = 1'b1;
                    else if (dir)  state_d = S_BUSREQ;
                    else           state_d = S_DEVIN;
                end
            end
            S_DEVIN: begin
                if (dev_in_valid)
                    state_d = (burst && own_q) ? S_MEMCYC : S_BUSREQ;
            end
            S_BUSREQ: begin
                if (bus_gnt) state_d = S_MEMCYC;
            end
            S_MEMCYC: begin
                if (!mem_wait) begin
                    word_step = 1'b1;
                    if (dir) begin
                        state_d = S_DEVOUT;
                    end else if (cnt_last) begin
                        fin     = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        state_d = S_DEVIN;
                    end
                end
            end
            S_DEVOUT: begin
                if (dev_out_ready) begin
                    if (cnt_zero) begin
                        fin     = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        state_d = burst ? S_MEMCYC : S_BUSREQ;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            own_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == S_IDLE)
                own_q <= 1'b0;
            else if (state_q == S_BUSREQ && bus_gnt)
                own_q <= 1'b1;
            if (state_q == S_DEVIN && dev_in_valid)
                data_q <= dev_in_data;
            else if (state_q == S_MEMCYC && !mem_wait && dir)
                data_q <= mem_rdata;
        end
    end

    always_comb begin
        busy          = (state_q != S_IDLE);
        mem_valid     = (state_q == S_MEMCYC);
        mem_we        = (state_q == S_MEMCYC) && !dir;
        dev_in_ready  = (state_q == S_DEVIN);
        dev_out_valid = (state_q == S_DEVOUT);
        bus_req       = (state_q == S_BUSREQ) || (state_q == S_MEMCYC) ||
                        (burst && own_q && (state_q == S_DEVIN || state_q == S_DEVOUT));
        mem_wdata     = data_q;
        dev_out_data  = data_q;
    end

    // R9: stealing mode gives the bus back after every word
    assert_steal_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst && word_step) |=> !bus_req);

    // R10: burst mode keeps the request from first grant to block end
    assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (burst && own_q && busy && !fin) |=> bus_req);

    // R13: memory cycle only under grant
    assert_gnt_R13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> bus_gnt);
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_en,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_wait,
    output logic          dev_out_valid,
    input  logic          dev_out_ready,
    output logic [DW-1:0] dev_out_data,
    input  logic          dev_in_valid,
    output logic          dev_in_ready,
    input  logic [DW-1:0] dev_in_data
);
    logic start_go, dir_eff, burst_eff, cnt_zero, cnt_last;
    logic word_step, fin, busy;

    dma_csr #(.AW(AW), .CW(CW)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .word_step (word_step),
        .fin       (fin),
        .start_go  (start_go),
        .dir_eff   (dir_eff),
        .burst_eff (burst_eff),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .addr_out  (mem_addr),
        .irq       (irq)
    );

    dma_seq #(.DW(DW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_go      (start_go),
        .dir           (dir_eff),
        .burst         (burst_eff),
        .cnt_zero      (cnt_zero),
        .cnt_last      (cnt_last),
        .bus_gnt       (bus_gnt),
        .bus_req       (bus_req),
        .mem_wait      (mem_wait),
        .mem_valid     (mem_valid),
        .mem_we        (mem_we),
        .mem_rdata     (mem_rdata),
        .mem_wdata     (mem_wdata),
        .dev_out_valid (dev_out_valid),
        .dev_out_ready (dev_out_ready),
        .dev_out_data  (dev_out_data),
        .dev_in_valid  (dev_in_valid),
        .dev_in_ready  (dev_in_ready),
        .dev_in_data   (dev_in_data),
        .word_step     (word_step),
        .fin           (fin),
        .busy          (busy)
    );

    // R12: a stalled cycle keeps address, data and direction
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_wait) |=> mem_valid && $stable(mem_addr) &&
                                    $stable(mem_wdata) && $stable(mem_we));
endmodule

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
    localparam int AW = 8;
    localparam int CW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_en = 1'b0, reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq, bus_req, mem_valid, mem_we;
    logic          bus_gnt, mem_wait, dev_out_ready, dev_in_valid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, dev_out_data, dev_in_data;
    logic          dev_out_valid, dev_in_ready;

    logic [31:0]   mem [256];
    logic [31:0]   sink [1024];
    logic [9:0]    sink_n;
    logic [31:0]   src_idx;

    logic          mon_clr = 1'b0;
    int            req_rise, mem_cyc, nogrant, stab_err;
    logic          req_d, pv, pw, pwe;
    logic [AW-1:0] pa;
    logic [DW-1:0] pd;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2ns clk = ~clk;

    dma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_dma_chan (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wait(mem_wait),
        .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
        .dev_out_data(dev_out_data), .dev_in_valid(dev_in_valid),
        .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data)
    );

    function automatic logic [31:0] init_val(int i);
        return (i * 32'h0101_0101) ^ 32'hC300_0000;
    endfunction

    function automatic logic [31:0] src_val(logic [31:0] i);
        return (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    assign mem_rdata   = mem[mem_addr];
    assign dev_in_data = src_val(src_idx);

    // memory, arbiter and device models
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            bus_gnt <= 1'b0; mem_wait <= 1'b0;
            dev_out_ready <= 1'b0; dev_in_valid <= 1'b0;
            src_idx <= '0; sink_n <= '0;
        end else begin
            if (mem_valid && !mem_wait && mem_we) mem[mem_addr] <= mem_wdata;
            mem_wait <= ($urandom % 3) == 0;
            if (!bus_req) bus_gnt <= 1'b0;
            else if (!bus_gnt) bus_gnt <= ($urandom % 2) == 0;
            dev_out_ready <= ($urandom % 4) != 0;
            if (dev_out_valid && dev_out_ready) begin
                sink[sink_n] <= dev_out_data;
                sink_n <= sink_n + 10'd1;
            end
            if (dev_in_valid && dev_in_ready) src_idx <= src_idx + 1;
            if (!dev_in_valid || dev_in_ready) dev_in_valid <= ($urandom % 4) != 0;
        end
    end

    // bus monitors
    always @(posedge clk) begin
        if (mon_clr) begin
            req_rise <= 0; mem_cyc <= 0; nogrant <= 0; stab_err <= 0;
        end else begin
            if (bus_req && !req_d) req_rise <= req_rise + 1;
            if (mem_valid && !mem_wait) mem_cyc <= mem_cyc + 1;
            if (mem_valid && !bus_gnt) nogrant <= nogrant + 1;
            if (pv && pw && (!mem_valid || mem_addr != pa || mem_wdata != pd || mem_we != pwe))
                stab_err <= stab_err + 1;
        end
        req_d <= bus_req; pv <= mem_valid; pw <= mem_wait;
        pa <= mem_addr; pd <= mem_wdata; pwe <= mem_we;
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1ps d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    function automatic logic [31:0] ctl(bit dir, bit burst, bit ie);
        return (32'(ie) << 30) | 32'h10 | (32'(burst) << 2) | 32'(dir);
    endfunction

    logic [31:0] src0;
    logic [9:0]  snk0;
    logic [31:0] guard;

    task automatic launch(int a, int n, bit dir, bit burst, bit ie);
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        src0 = src_idx; snk0 = sink_n; guard = mem[a + n];
        reg_wr(2'd0, 32'(a));
        reg_wr(2'd1, 32'(n));
        reg_wr(2'd2, ctl(dir, burst, ie));
    endtask

    task automatic finish(int a, int n, bit dir, bit burst, bit ie);
        logic [31:0] st, v;
        int bad;
        bit got;
        got = 0;
        if (ie) begin
            for (int t = 0; t < 6000 && !got; t++) begin
                @(negedge clk);
                if (irq) got = 1;
            end
            check(got, "R6 irq raised at completion", 32'(got), 1);
            reg_rd(2'd2, st);
            check(st[1] && st[31], "R5/R6 done and irq bits", st, 32'h8000_0002);
            check(!irq, "R7 status read clears irq", 32'(irq), 0);
            reg_rd(2'd2, st);
            check(!st[31], "R7 irq bit cleared", st, 0);
        end else begin
            for (int t = 0; t < 3000 && !got; t++) begin
                reg_rd(2'd2, st);
                if (st[1]) got = 1;
            end
            check(got, "R5 done set after block", st, 32'h2);
            check(!irq && !st[31], "R6 no irq when disabled", st, 0);
        end
        reg_rd(2'd0, v);
        check(v == 32'((a + n) % 256), "R2 address after block", v, 32'((a + n) % 256));
        reg_rd(2'd1, v);
        check(v == 0, "R2 count after block", v, 0);
        bad = 0;
        if (dir) begin
            for (int i = 0; i < n; i++)
                if (sink[10'(snk0 + 10'(i))] != mem[a + i]) bad++;
            check(bad == 0, "R3 memory to device data", 32'(bad), 0);
            check(10'(sink_n - snk0) == 10'(n), "R3 word count to device", 32'(sink_n - snk0), 32'(n));
        end else begin
            for (int i = 0; i < n; i++)
                if (mem[a + i] != src_val(src0 + 32'(i))) bad++;
            check(bad == 0, "R4 device to memory data", 32'(bad), 0);
            check(mem[a + n] == guard, "R4 word past block untouched", mem[a + n], guard);
        end
        if (n > 0) begin
            if (burst) check(req_rise == 1, "R10 one request per block", 32'(req_rise), 1);
            else       check(req_rise == n, "R9 one request per word", 32'(req_rise), 32'(n));
        end
        check(mem_cyc == n, "R2 memory cycles per block", 32'(mem_cyc), 32'(n));
        check(nogrant == 0, "R13 cycle only under grant", 32'(nogrant), 0);
        check(stab_err == 0, "R12 stalled cycle stable", 32'(stab_err), 0);
    endtask

    initial begin
        logic [31:0] st;
        void'($urandom(32'h00C0_FFEE));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_rd(2'd2, st);
        check(st == 0, "R1 status after reset", st, 0);
        check(!irq && !bus_req && !mem_valid, "R1 outputs idle after reset",
              {29'd0, irq, bus_req, mem_valid}, 0);

        // R8 zero count with interrupt enabled
        launch(10, 0, 1'b1, 1'b0, 1'b1);
        check(irq, "R8 zero count completes at once", 32'(irq), 1);
        finish(10, 0, 1'b1, 1'b0, 1'b1);

        // single-word edge cases
        launch(40, 1, 1'b1, 1'b0, 1'b0); finish(40, 1, 1'b1, 1'b0, 1'b0);
        launch(41, 1, 1'b0, 1'b1, 1'b1); finish(41, 1, 1'b0, 1'b1, 1'b1);

        // R11 launch while busy is rejected, R5 done clear while busy
        launch(100, 20, 1'b1, 1'b0, 1'b0);
        reg_wr(2'd2, ctl(1'b0, 1'b1, 1'b1));
        reg_rd(2'd2, st);
        check(st[3], "R11 error flag on busy launch", st, 32'h8);
        check(!st[1], "R5 done clear while busy", st, 0);
        check(!st[2] && st[0] && !st[30], "R11 busy launch left fields unchanged", st, 32'h1);
        finish(100, 20, 1'b1, 1'b0, 1'b0);
        launch(130, 3, 1'b0, 1'b0, 1'b0);
        reg_rd(2'd2, st);
        check(!st[3], "R11 error cleared by accepted launch", st, 0);
        finish(130, 3, 1'b0, 1'b0, 1'b0);

        // constrained random blocks
        for (int k = 0; k < 12; k++) begin
            int a, n;
            bit d, b, e;
            a = $urandom % 200;
            n = 1 + ($urandom % 24);
            d = 1'($urandom); b = 1'($urandom); e = 1'($urandom);
            launch(a, n, d, b, e);
            finish(a, n, d, b, e);
        end

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog R5 run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule